// File: doc/BRIEF.md
# Double-Buffered Converter Code Register

This block is the host-facing register logic of a 16-bit parallel digital-to-analog converter. A host writes a word over a 16-bit bidirectional data bus into a staging register. It can read that word back over the same bus. A separate load strobe copies the staged word into the output register, and that register supplies the conversion code. Because loading is separate from writing, several converters can be staged one at a time and then updated together with one shared load strobe.

A clear input forces the output register to a fixed code, whatever the state of the bus interface. The code depends on the read/write line. With write selected it loads all zeros, which is 0 V in a unipolar setup. With read selected it loads mid-scale, which is 0 V in an offset-binary bipolar setup. All control lines and the bus arrive asynchronously. They are brought into the block clock domain by synchroniser chains, and every action is then taken on the synchronised copies.

Top module: `dac_host_regs`

## Requirements
- R1: While reset is asserted, the staging word and the output code are 16'h0000 and the bus output enable is low.
- R2: Whenever chip select has been high for longer than the synchroniser latency, the bus output enable is low and the bus output word is all zeros, whatever the other controls are doing.
- R3: A write (chip select low and read/write low) updates the staging word only when the write ends. The word stored is the last bus value seen while the write was active. Bus changes after the write ends are not stored.
- R4: With chip select low and read/write high, the output enable is high and the bus output word equals the staging word, bit 15 the MSB and bit 0 the LSB.
- R5: With load low and clear high, the output code takes the staging word, whether chip select is high or low.
- R6: With clear low and read/write low, the output code becomes 16'h0000.
- R7: With clear low and read/write high, the output code becomes 16'h8000, only bit 15 set.
- R8: When clear and load are both low, the clear value wins.
- R9: While load and clear are both high, the output code holds its value, including across writes.
- R10: With load held low permanently, the output code follows the staging word, so one write updates the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip select |
| rw_i | input | 1 | 1 = read, 0 = write; also picks the clear value |
| ld_n_i | input | 1 | Active-low load strobe into the output register |
| clr_n_i | input | 1 | Active-low clear of the output register |
| bus_in_i | input | 16 | Data bus, pad input side |
| bus_out_o | output | 16 | Data bus, pad output side (zero when not driving) |
| bus_oe_o | output | 1 | Pad output enable for the data bus |
| code_o | output | 16 | Output register code to the converter core |

## Verification
The bench builds the block with its defaults: a 16-bit data width and two synchroniser stages. With these values the mid-scale code is 16'h8000, and each input change shows at the outputs three clock edges later. The bench therefore drives every control change for several cycles and waits a fixed settle time before it samples. The two-stage chain keeps the write-end case within reach: bus data is changed in the same cycle that chip select rises, and both travel down equal-length pipelines. Simultaneous clear and load, and loads with the bus selected for reading, are driven on purpose, as well as through random sequences.

// File: rtl/dhr_pkg.sv
package dhr_pkg;

    // synchronised copy of the host control lines
    typedef struct packed {
        logic cs_n;
        logic rw;
        logic ld_n;
        logic clr_n;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // idle level of every control line: nothing selected, nothing strobed
    localparam logic [CTL_W-1:0] CTL_IDLE = {CTL_W{1'b1}};

endpackage

// File: rtl/dhr_sync.sv
module dhr_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= RST_VAL;
            end else begin
                stage_q[g] <= stage_d[g];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dhr_in_latch.sv
module dhr_in_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n_s,
    input  logic         rw_s,
    input  logic [W-1:0] data_s,
    output logic [W-1:0] word_o,
    output logic         oe_o
);

    typedef struct packed {
        logic         wr_act;   // write strobe seen active last cycle
        logic         oe;       // readback drive enable
        logic [W-1:0] hold;     // last bus value during the strobe
        logic [W-1:0] word;     // staging register
    } st_t;

    st_t  st_q, st_d;
    logic wr_now;

    always_comb begin
        st_d   = st_q;
        wr_now = !cs_n_s && !rw_s;

        st_d.wr_act = wr_now;
        if (wr_now) begin
            st_d.hold = data_s;
        end
        // strobe just ended: commit what was on the bus while it was active
        if (st_q.wr_act && !wr_now) begin
            st_d.word = st_q.hold;
        end
        st_d.oe = !cs_n_s && rw_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
    assign oe_o   = st_q.oe;

endmodule

// File: rtl/dhr_out_latch.sv
module dhr_out_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_n_s,
    input  logic         clr_n_s,
    input  logic         rw_s,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] code_o
);

    localparam logic [W-1:0] ZERO_CODE = '0;
    localparam logic [W-1:0] MID_CODE  = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] code_q, code_d;

    always_comb begin
        code_d = code_q;
        if (!clr_n_s) begin
            code_d = rw_s ? MID_CODE : ZERO_CODE;
        end else if (!ld_n_s) begin
            code_d = word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= ZERO_CODE;
        end else begin
            code_q <= code_d;
        end
    end

    assign code_o = code_q;

endmodule

// File: rtl/dac_host_regs.sv
module dac_host_regs #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              rw_i,
    input  logic              ld_n_i,
    input  logic              clr_n_i,
    input  logic [DATA_W-1:0] bus_in_i,
    output logic [DATA_W-1:0] bus_out_o,
    output logic              bus_oe_o,
    output logic [DATA_W-1:0] code_o
);
    import dhr_pkg::*;

    ctl_t              ctl_raw, ctl_s;
    logic [CTL_W-1:0]  ctl_bits_s;
    logic [DATA_W-1:0] data_s;
    logic [DATA_W-1:0] word;
    logic              oe;

    assign ctl_raw = '{cs_n: cs_n_i, rw: rw_i, ld_n: ld_n_i, clr_n: clr_n_i};

    dhr_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ctl_raw),
        .q_o   (ctl_bits_s)
    );
    assign ctl_s = ctl_t'(ctl_bits_s);

    // same depth as the controls so data and strobe stay aligned
    dhr_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bus_in_i),
        .q_o   (data_s)
    );

    dhr_in_latch #(.W(DATA_W)) u_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n_s (ctl_s.cs_n),
        .rw_s   (ctl_s.rw),
        .data_s (data_s),
        .word_o (word),
        .oe_o   (oe)
    );

    dhr_out_latch #(.W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_n_s  (ctl_s.ld_n),
        .clr_n_s (ctl_s.clr_n),
        .rw_s    (ctl_s.rw),
        .word_i  (word),
        .code_o  (code_o)
    );

    always_comb begin
        bus_oe_o  = oe;
        bus_out_o = oe ? word : '0;
    end

endmodule

// File: rtl/dhr_checker.sv
module dhr_checker #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_i,
    input logic              rw_i,
    input logic              ld_n_i,
    input logic              clr_n_i,
    input logic [DATA_W-1:0] bus_out_o,
    input logic              bus_oe_o,
    input logic [DATA_W-1:0] code_o
);

    localparam int LIM = SYNC_STAGES + 2;
    localparam int CW  = $clog2(LIM + 1) + 1;
    localparam logic [CW-1:0] LIM_C = CW'(LIM);
    localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

    logic [CW-1:0] cs_hi_run, clr_w_run, clr_r_run, quiet_run;
    logic          rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_hi_run <= '0;
            clr_w_run <= '0;
            clr_r_run <= '0;
            quiet_run <= '0;
        end else begin
            cs_hi_run <= !cs_n_i ? '0 : (cs_hi_run == LIM_C ? LIM_C : cs_hi_run + 1'b1);
            clr_w_run <= (clr_n_i || rw_i) ? '0 :
                         (clr_w_run == LIM_C ? LIM_C : clr_w_run + 1'b1);
            clr_r_run <= (clr_n_i || !rw_i) ? '0 :
                         (clr_r_run == LIM_C ? LIM_C : clr_r_run + 1'b1);
            quiet_run <= (!clr_n_i || !ld_n_i) ? '0 :
                         (quiet_run == LIM_C ? LIM_C : quiet_run + 1'b1);
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst_seen_q |-> (code_o == '0 && !bus_oe_o));

    // R2
    deselect_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_run == LIM_C) |-> (!bus_oe_o && bus_out_o == '0));

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w_run == LIM_C) |-> (code_o == '0));

    // R7
    clear_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_r_run == LIM_C) |-> (code_o == MID));

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_run == LIM_C) |-> $stable(code_o));

endmodule

bind dac_host_regs dhr_checker #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_i    (cs_n_i),
    .rw_i      (rw_i),
    .ld_n_i    (ld_n_i),
    .clr_n_i   (clr_n_i),
    .bus_out_o (bus_out_o),
    .bus_oe_o  (bus_oe_o),
    .code_o    (code_o)
);

// File: tb/sim_dac_host_regs.sv
module sim_dac_host_regs;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 6;
    localparam int N_RANDOM   = 150;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rw = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out, code;
    logic        bus_oe;

    int errors = 0;
    int checks = 0;
    logic [15:0] in_m  = '0;
    logic [15:0] out_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_host_regs u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .rw_i(rw), .ld_n_i(ld_n),
        .clr_n_i(clr_n), .bus_in_i(bus_in), .bus_out_o(bus_out),
        .bus_oe_o(bus_oe), .code_o(code)
    );

    function automatic logic [15:0] clear_value(input logic rd);
        return rd ? 16'h8000 : 16'h0000;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] d);
        rw = 1'b0; bus_in = d; tick(1);
        cs_n = 1'b0; tick(4);
        cs_n = 1'b1; bus_in = 16'($urandom);   // R3: post-strobe change is ignored
        tick(1); rw = 1'b1; tick(SETTLE);
        in_m = d;
    endtask

    task automatic do_read(input string req);
        rw = 1'b1; cs_n = 1'b0; tick(SETTLE);
        chk(req, {15'b0, bus_oe}, 16'd1);
        chk(req, bus_out, in_m);
        cs_n = 1'b1; tick(SETTLE);
        chk("R2", {15'b0, bus_oe}, 16'd0);
        chk("R2", bus_out, 16'h0000);
    endtask

    task automatic do_load();
        ld_n = 1'b0; tick(3); ld_n = 1'b1; tick(SETTLE);
        out_m = in_m;
        chk("R5", code, out_m);
    endtask

    task automatic do_clear(input logic rd);
        rw = rd; tick(1); clr_n = 1'b0; tick(3); clr_n = 1'b1; tick(1); rw = 1'b1;
        tick(SETTLE);
        out_m = clear_value(rd);
        chk(rd ? "R7" : "R6", code, out_m);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        tick(3);
        // R1: state while reset is held
        chk("R1", code, 16'h0000);
        chk("R1", {15'b0, bus_oe}, 16'd0);
        rst_n = 1'b1; tick(SETTLE);
        do_read("R1");   // staging word still zero after reset

        // R2: deselected while other lines toggle
        rw = 1'b0; ld_n = 1'b0; tick(SETTLE);
        chk("R2", {15'b0, bus_oe}, 16'd0);
        chk("R2", bus_out, 16'h0000);
        ld_n = 1'b1; rw = 1'b1; tick(SETTLE);

        // R3/R4/R9: write, code holds, then readback
        do_write(16'hA5C3);
        chk("R9", code, out_m);
        do_read("R4");
        do_load();

        // R10 and R3 capture point: load held low permanently
        ld_n = 1'b0; tick(SETTLE);
        chk("R10", code, in_m);
        rw = 1'b0; bus_in = 16'h1234; tick(1); cs_n = 1'b0; tick(SETTLE);
        chk("R3", code, 16'hA5C3);      // no update while strobe is active
        bus_in = 16'h0F0F; tick(2);     // last value during strobe counts
        cs_n = 1'b1; bus_in = 16'hFFFF; tick(1); rw = 1'b1; tick(SETTLE);
        in_m = 16'h0F0F; out_m = in_m;
        chk("R10", code, 16'h0F0F);
        ld_n = 1'b1; tick(SETTLE);
        do_read("R3");

        // R8: clear and load together, both polarities
        for (int k = 0; k < 2; k++) begin
            rw = logic'(k); tick(1); clr_n = 1'b0; ld_n = 1'b0; tick(SETTLE);
            chk("R8", code, clear_value(logic'(k)));
            clr_n = 1'b1; ld_n = 1'b1; tick(1); rw = 1'b1; tick(SETTLE);
            out_m = clear_value(logic'(k));
            chk("R8", code, out_m);
        end

        // R5: load while the bus is selected for readback
        rw = 1'b1; cs_n = 1'b0; tick(2);
        ld_n = 1'b0; tick(3); ld_n = 1'b1; tick(SETTLE);
        out_m = in_m;
        chk("R5", code, out_m);
        chk("R4", bus_out, in_m);
        cs_n = 1'b1; tick(SETTLE);

        // boundary words
        do_write(16'hFFFF); do_read("R4"); do_load();
        do_write(16'h0001); do_read("R4"); do_load();
        do_clear(1'b0); do_clear(1'b1);

        // constrained random sequence
        for (int n = 0; n < N_RANDOM; n++) begin
            case ($urandom_range(0, 4))
                0, 1: begin
                    do_write(16'($urandom));
                    chk("R9", code, out_m);
                end
                2: do_read("R4");
                3: do_load();
                default: do_clear(logic'($urandom_range(0, 1)));
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule